// File: doc/BRIEF.md
# Indirect Addressing Pointer Unit

This block holds a small set of 12-bit data-memory pointers and turns an indirect access request into an effective address. The instruction decode supplies the pointer index, the access flavour, and the current working-register value. The block returns the address to use in the same cycle. On the next clock edge it commits any pointer step that the flavour implies. Five flavours are offered: plain, post-increment, pre-increment, post-decrement, and base-plus-signed-W offset.

Software reaches each pointer as two byte-wide halves. The low half carries bits 7:0. The high half carries bits 11:8 in its low nibble, and its upper nibble reads as zero. A pointer can also be loaded with a full 12-bit literal in a single cycle. All pointer arithmetic is modulo 4096 and produces no carry or status indication. The data memory and the instruction decoder live outside this block.

Top module: `ptr_indirect_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every pointer becomes 0x000.
- R2: A literal load (`lit_valid`) writes `lit_value` into pointer `lit_sel` at the next edge. It takes precedence over a byte write and over an access step on the same pointer.
- R3: A byte write with `byte_hi`=0 replaces bits 7:0 of pointer `byte_sel`. With `byte_hi`=1 it replaces bits 11:8 with `byte_data[3:0]` and discards `byte_data[7:4]`. A byte write takes precedence over an access step on the same pointer.
- R4: `rd_data` shows pointer `rd_sel` combinationally. With `rd_hi`=0 it shows bits 7:0. With `rd_hi`=1 it shows bits 11:8 in bits 3:0, and bits 7:4 read as zero. A selector of 3 reads 0x00.
- R5: Mode 0 (plain): `eff_addr` equals the pointer, and the pointer is unchanged.
- R6: Mode 1 (post-increment): `eff_addr` equals the pointer, and the pointer then becomes pointer+1.
- R7: Mode 2 (pre-increment): `eff_addr` equals pointer+1, and the pointer becomes that same value.
- R8: Mode 3 (post-decrement): `eff_addr` equals the pointer, and the pointer then becomes pointer-1.
- R9: Mode 4 (plus-W): `eff_addr` equals the pointer plus `w_val` read as a signed 8-bit value, modulo 4096. The pointer is unchanged.
- R10: Increment wraps 0xFFF to 0x000, and decrement wraps 0x000 to 0xFFF, with no other effect.
- R11: Modes 5 to 7 behave as plain. With `acc_valid` low, or with `acc_sel`=3, `eff_addr` is 0x000 and no pointer changes.
- R12: An access step on one pointer leaves the other pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Indirect access this cycle |
| acc_sel | input | 2 | Pointer used by the access |
| acc_mode | input | 3 | Access flavour code |
| w_val | input | 8 | Working-register value for plus-W |
| eff_addr | output | 12 | Effective data address |
| lit_valid | input | 1 | 12-bit literal load strobe |
| lit_sel | input | 2 | Pointer loaded by the literal |
| lit_value | input | 12 | Literal value |
| byte_wr | input | 1 | Byte write strobe |
| byte_sel | input | 2 | Pointer written by byte |
| byte_hi | input | 1 | 1 selects the high half |
| byte_data | input | 8 | Byte write data |
| rd_sel | input | 2 | Pointer shown on rd_data |
| rd_hi | input | 1 | 1 selects the high half |
| rd_data | output | 8 | Byte readback |
| ptr_bus | output | 36 | All pointers, pointer i at bits 12i+11:12i |

## Verification
The bench targets both wrap points. A design that propagates a carry out of bit 11 or stops at a limit would show a non-zero address after 0xFFF+1 or a value other than 0xFFF after 0x000-1. Plus-W runs with negative, most-negative, and carry-producing W values, which exposes an offset that is zero-extended instead of sign-extended. Pre-increment is checked separately from post-increment, because swapping the two moves the address by one. Same-cycle literal-versus-step and byte-versus-step collisions, out-of-range selectors, and unused mode codes are checked so that a wrong priority or a stray update on another pointer shows up in the pointer values.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

    typedef enum logic [2:0] {
        ACC_PLAIN   = 3'd0,
        ACC_POSTINC = 3'd1,
        ACC_PREINC  = 3'd2,
        ACC_POSTDEC = 3'd3,
        ACC_PLUSW   = 3'd4
    } acc_mode_e;

    typedef struct packed {
        logic step;   // pointer is written back
        logic down;   // step is -1 instead of +1
        logic pre;    // address uses stepped value
        logic offs;   // address uses base + signed W
    } acc_op_t;

    function automatic acc_op_t decode_mode(input logic [2:0] code);
        acc_op_t op;
        op = '0;
        case (code)
            ACC_POSTINC: op.step = 1'b1;
            ACC_PREINC: begin
                op.step = 1'b1;
                op.pre  = 1'b1;
            end
            ACC_POSTDEC: begin
                op.step = 1'b1;
                op.down = 1'b1;
            end
            ACC_PLUSW: op.offs = 1'b1;
            default: op = '0;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc
    import ptr_pkg::*;
#(
    parameter int PTR_W = 12,
    parameter int W_W   = 8
) (
    input  logic [PTR_W-1:0] base,
    input  logic [2:0]       mode,
    input  logic [W_W-1:0]   w_val,
    output logic [PTR_W-1:0] eff,
    output logic [PTR_W-1:0] nxt,
    output logic             upd
);
    localparam int EXT_W = PTR_W - W_W;

    acc_op_t          op;
    logic [PTR_W-1:0] inc_v;
    logic [PTR_W-1:0] dec_v;
    logic [PTR_W-1:0] off_v;

    always_comb begin
        op    = decode_mode(mode);
        inc_v = base + PTR_W'(1);
        dec_v = base - PTR_W'(1);
        off_v = base + {{EXT_W{w_val[W_W-1]}}, w_val};
        if (op.offs)     eff = off_v;
        else if (op.pre) eff = inc_v;
        else             eff = base;
        nxt = op.down ? dec_v : inc_v;
        upd = op.step;
    end
endmodule

// File: rtl/ptr_reg_slot.sv
module ptr_reg_slot #(
    parameter int PTR_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lit_en,
    input  logic [PTR_W-1:0]  lit_val,
    input  logic              lo_en,
    input  logic              hi_en,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              step_en,
    input  logic [PTR_W-1:0]  step_val,
    output logic [PTR_W-1:0]  q
);
    localparam int HI_W = PTR_W - DATA_W;

    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (lit_en)  q <= lit_val;
        else if (lo_en)   q[DATA_W-1:0] <= byte_data;
        else if (hi_en)   q[PTR_W-1:DATA_W] <= byte_data[HI_W-1:0];
        else if (step_en) q <= step_val;
    end
endmodule

// File: rtl/ptr_indirect_unit.sv
module ptr_indirect_unit #(
    parameter int PTR_W   = 12,
    parameter int DATA_W  = 8,
    parameter int NUM_PTR = 3,
    localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     acc_valid,
    input  logic [SEL_W-1:0]         acc_sel,
    input  logic [2:0]               acc_mode,
    input  logic [DATA_W-1:0]        w_val,
    output logic [PTR_W-1:0]         eff_addr,
    input  logic                     lit_valid,
    input  logic [SEL_W-1:0]         lit_sel,
    input  logic [PTR_W-1:0]         lit_value,
    input  logic                     byte_wr,
    input  logic [SEL_W-1:0]         byte_sel,
    input  logic                     byte_hi,
    input  logic [DATA_W-1:0]        byte_data,
    input  logic [SEL_W-1:0]         rd_sel,
    input  logic                     rd_hi,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_PTR*PTR_W-1:0] ptr_bus
);
    localparam int HI_W = PTR_W - DATA_W;

    logic [PTR_W-1:0] ptr_q [NUM_PTR];
    logic [PTR_W-1:0] base;
    logic             hit;
    logic [PTR_W-1:0] calc_eff;
    logic [PTR_W-1:0] calc_nxt;
    logic             calc_upd;

    always_comb begin
        base = '0;
        hit  = 1'b0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (acc_sel == SEL_W'(i)) begin
                base = ptr_q[i];
                hit  = 1'b1;
            end
        end
    end

    ptr_addr_calc #(.PTR_W(PTR_W), .W_W(DATA_W)) u_calc (
        .base  (base),
        .mode  (acc_mode),
        .w_val (w_val),
        .eff   (calc_eff),
        .nxt   (calc_nxt),
        .upd   (calc_upd)
    );

    assign eff_addr = (acc_valid && hit) ? calc_eff : '0;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_slot
        logic is_lit, is_lo, is_hi, is_step;
        assign is_lit  = lit_valid && (lit_sel == SEL_W'(g));
        assign is_lo   = byte_wr && !byte_hi && (byte_sel == SEL_W'(g));
        assign is_hi   = byte_wr &&  byte_hi && (byte_sel == SEL_W'(g));
        assign is_step = acc_valid && calc_upd && (acc_sel == SEL_W'(g));

        ptr_reg_slot #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .lit_en    (is_lit),
            .lit_val   (lit_value),
            .lo_en     (is_lo),
            .hi_en     (is_hi),
            .byte_data (byte_data),
            .step_en   (is_step),
            .step_val  (calc_nxt),
            .q         (ptr_q[g])
        );
        assign ptr_bus[g*PTR_W +: PTR_W] = ptr_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_data = rd_hi ? {{(DATA_W-HI_W){1'b0}}, ptr_q[i][PTR_W-1:DATA_W]}
                                : ptr_q[i][DATA_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ptr_indirect_unit_chk.sv
module ptr_indirect_unit_chk #(
    parameter int PTR_W   = 12,
    parameter int DATA_W  = 8,
    parameter int NUM_PTR = 3,
    localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     acc_valid,
    input logic [SEL_W-1:0]         acc_sel,
    input logic [2:0]               acc_mode,
    input logic [PTR_W-1:0]         eff_addr,
    input logic                     lit_valid,
    input logic                     byte_wr,
    input logic                     rd_hi,
    input logic [DATA_W-1:0]        rd_data,
    input logic [NUM_PTR*PTR_W-1:0] ptr_bus
);
    localparam int HI_W = PTR_W - DATA_W;

    function automatic logic [PTR_W-1:0] selp(input logic [NUM_PTR*PTR_W-1:0] bus,
                                               input logic [SEL_W-1:0] s);
        logic [PTR_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_PTR; i++)
            if (s == SEL_W'(i)) r = bus[i*PTR_W +: PTR_W];
        return r;
    endfunction

    logic solo;
    assign solo = acc_valid && (int'(acc_sel) < NUM_PTR) && !lit_valid && !byte_wr;

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> ptr_bus == '0);

    p_hi_nibble_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rd_hi |-> (rd_data >> HI_W) == '0);

    p_plain_hold_r5: assert property (@(posedge clk) disable iff (rst)
        solo && acc_mode == 3'd0 |=>
            selp(ptr_bus, $past(acc_sel)) == $past(selp(ptr_bus, acc_sel)));

    p_postinc_step_r6: assert property (@(posedge clk) disable iff (rst)
        solo && acc_mode == 3'd1 |=>
            selp(ptr_bus, $past(acc_sel)) == $past(selp(ptr_bus, acc_sel)) + PTR_W'(1));

    p_preinc_addr_r7: assert property (@(posedge clk) disable iff (rst)
        solo && acc_mode == 3'd2 |-> eff_addr == selp(ptr_bus, acc_sel) + PTR_W'(1));

    p_postdec_step_r8: assert property (@(posedge clk) disable iff (rst)
        solo && acc_mode == 3'd3 |=>
            selp(ptr_bus, $past(acc_sel)) == $past(selp(ptr_bus, acc_sel)) - PTR_W'(1));

    p_plusw_hold_r9: assert property (@(posedge clk) disable iff (rst)
        solo && acc_mode == 3'd4 |=>
            selp(ptr_bus, $past(acc_sel)) == $past(selp(ptr_bus, acc_sel)));

    p_idle_addr_r11: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> eff_addr == '0);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !acc_valid && !lit_valid && !byte_wr |=> $stable(ptr_bus));
endmodule

bind ptr_indirect_unit ptr_indirect_unit_chk #(
    .PTR_W(PTR_W), .DATA_W(DATA_W), .NUM_PTR(NUM_PTR)
) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_sel(acc_sel),
    .acc_mode(acc_mode), .eff_addr(eff_addr), .lit_valid(lit_valid),
    .byte_wr(byte_wr), .rd_hi(rd_hi), .rd_data(rd_data), .ptr_bus(ptr_bus)
);

// File: tb/ptr_indirect_unit_test.sv
module ptr_indirect_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_sel = '0;
    logic [2:0]  acc_mode = '0;
    logic [7:0]  w_val = '0;
    logic [11:0] eff_addr;
    logic        lit_valid = 1'b0;
    logic [1:0]  lit_sel = '0;
    logic [11:0] lit_value = '0;
    logic        byte_wr = 1'b0;
    logic [1:0]  byte_sel = '0;
    logic        byte_hi = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [1:0]  rd_sel = '0;
    logic        rd_hi = 1'b0;
    logic [7:0]  rd_data;
    logic [35:0] ptr_bus;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ptr_indirect_unit uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_sel(acc_sel),
        .acc_mode(acc_mode), .w_val(w_val), .eff_addr(eff_addr),
        .lit_valid(lit_valid), .lit_sel(lit_sel), .lit_value(lit_value),
        .byte_wr(byte_wr), .byte_sel(byte_sel), .byte_hi(byte_hi),
        .byte_data(byte_data), .rd_sel(rd_sel), .rd_hi(rd_hi),
        .rd_data(rd_data), .ptr_bus(ptr_bus)
    );

    typedef struct packed {
        logic [11:0] init;
        logic [1:0]  sel;
        logic [2:0]  mode;
        logic [7:0]  w;
        logic [11:0] exp_eff;
        logic [11:0] exp_ptr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{12'h130, 2'd0, 3'd0, 8'h00, 12'h130, 12'h130},  // R5
        '{12'h040, 2'd1, 3'd1, 8'h00, 12'h040, 12'h041},  // R6
        '{12'hFFF, 2'd2, 3'd1, 8'h00, 12'hFFF, 12'h000},  // R10
        '{12'h0FF, 2'd0, 3'd2, 8'h00, 12'h100, 12'h100},  // R7
        '{12'hFFF, 2'd1, 3'd2, 8'h00, 12'h000, 12'h000},  // R10
        '{12'h200, 2'd2, 3'd3, 8'h00, 12'h200, 12'h1FF},  // R8
        '{12'h000, 2'd0, 3'd3, 8'h00, 12'h000, 12'hFFF},  // R10
        '{12'h130, 2'd1, 3'd4, 8'h05, 12'h135, 12'h130},  // R9
        '{12'h010, 2'd2, 3'd4, 8'hF0, 12'h000, 12'h010},  // R9
        '{12'h005, 2'd0, 3'd4, 8'h80, 12'hF85, 12'h005},  // R9
        '{12'hFF0, 2'd1, 3'd4, 8'h7F, 12'h06F, 12'hFF0},  // R9
        '{12'h3A5, 2'd2, 3'd6, 8'h11, 12'h3A5, 12'h3A5}   // R11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] pv(input int s);
        return ptr_bus[s*12 +: 12];
    endfunction

    task automatic idle();
        acc_valid = 1'b0; lit_valid = 1'b0; byte_wr = 1'b0;
    endtask

    task automatic load(input logic [1:0] s, input logic [11:0] v);
        @(negedge clk);
        idle();
        lit_valid = 1'b1; lit_sel = s; lit_value = v;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ptr_bus after reset", 32'(ptr_bus), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        rd_sel = 2'd2; rd_hi = 1'b0; #2;
        chk("R1 readback after reset", 32'(rd_data), 32'h0);

        for (int i = 0; i < NV; i++) begin
            load(VEC[i].sel, VEC[i].init);
            acc_valid = 1'b1; acc_sel = VEC[i].sel;
            acc_mode = VEC[i].mode; w_val = VEC[i].w;
            #2;
            chk($sformatf("R5-9 vec%0d eff_addr", i), 32'(eff_addr), 32'(VEC[i].exp_eff));
            @(negedge clk);
            idle();
            #2;
            chk($sformatf("R6-10 vec%0d pointer", i), 32'(pv(int'(VEC[i].sel))),
                32'(VEC[i].exp_ptr));
        end

        // R3 and R4: byte writes and readback
        load(2'd1, 12'h000);
        byte_wr = 1'b1; byte_sel = 2'd1; byte_hi = 1'b0; byte_data = 8'hAB;
        @(negedge clk);
        byte_hi = 1'b1; byte_data = 8'hF7;
        @(negedge clk);
        idle(); #2;
        chk("R3 byte halves compose", 32'(pv(1)), 32'h7AB);
        rd_sel = 2'd1; rd_hi = 1'b1; #1;
        chk("R4 high half readback", 32'(rd_data), 32'h07);
        rd_hi = 1'b0; #1;
        chk("R4 low half readback", 32'(rd_data), 32'hAB);
        rd_sel = 2'd3; #1;
        chk("R4 selector 3 reads zero", 32'(rd_data), 32'h0);

        // R2: literal beats a same-cycle step
        load(2'd0, 12'h100);
        lit_valid = 1'b1; lit_sel = 2'd0; lit_value = 12'h5C3;
        acc_valid = 1'b1; acc_sel = 2'd0; acc_mode = 3'd1;
        @(negedge clk);
        idle(); #2;
        chk("R2 literal over step", 32'(pv(0)), 32'h5C3);

        // R3: byte write beats a same-cycle step
        byte_wr = 1'b1; byte_sel = 2'd0; byte_hi = 1'b0; byte_data = 8'h11;
        acc_valid = 1'b1; acc_sel = 2'd0; acc_mode = 3'd3;
        @(negedge clk);
        idle(); #2;
        chk("R3 byte over step", 32'(pv(0)), 32'h511);

        // R11: selector 3 and idle
        load(2'd2, 12'h777);
        acc_valid = 1'b1; acc_sel = 2'd3; acc_mode = 3'd1; #2;
        chk("R11 selector 3 address", 32'(eff_addr), 32'h0);
        @(negedge clk);
        idle(); #2;
        chk("R11 selector 3 no update", 32'(ptr_bus), 32'({12'h777, 12'h7AB, 12'h511}));
        acc_sel = 2'd2; acc_mode = 3'd1; #1;
        chk("R11 idle address zero", 32'(eff_addr), 32'h0);
        @(negedge clk); #2;
        chk("R11 idle no update", 32'(pv(2)), 32'h777);

        // R12: independence
        acc_valid = 1'b1; acc_sel = 2'd1; acc_mode = 3'd2;
        @(negedge clk);
        idle(); #2;
        chk("R12 stepped pointer", 32'(pv(1)), 32'h7AC);
        chk("R12 neighbour 0", 32'(pv(0)), 32'h511);
        chk("R12 neighbour 2", 32'(pv(2)), 32'h777);

        // R1: mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; #2;
        chk("R1 mid-run reset", 32'(ptr_bus), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule